// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block holds the active 8-bit gain code of one audio channel and decides the cycle in which a newly requested code replaces it. A serial control port in front of it delivers a requested code with a one-cycle strobe. An analog comparator delivers the polarity of the channel input as one bit per clock, high while the signal is negative. A free-running divider delivers a one-cycle pulse every millisecond. The active code drives the analog switch array. The block also outputs a mute flag and the gain as a signed count of half-dB steps, for monitoring logic.

When zero-crossing updates are disabled, a request takes effect on the next clock edge. When they are enabled, a differing request is held as pending. It takes effect at the next rising zero crossing of the input, which is a negative sample followed by a non-negative one. If no such crossing arrives within sixteen millisecond ticks, it takes effect anyway. Code 0 is the muted condition. Any other code N gives a gain of 31.5 − 0.5·(255 − N) dB.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset the active code is 0, the mute flag is 1 and the half-dB gain output is 0.
- R2: With the enable input low, a strobed request is the active code after the next clock edge.
- R3: For an active code N from 1 to 255, the gain output is the signed value N − 192 in half-dB steps: 255 gives +63, 192 gives 0 and 1 gives −191. The mute flag is 0 for these codes.
- R4: Active code 0 sets the mute flag to 1 and the gain output to 0.
- R5: With the enable input high, a request that differs from the active code becomes pending. The active code stays unchanged until a clock edge at which the polarity input is 0 and was 1 at the edge before. The pending code is active after that edge.
- R6: A polarity change from 0 to 1, or a polarity held at a constant value, does not apply a pending code.
- R7: If no rising crossing occurs, a pending code becomes active after the 16th millisecond tick that follows the request, and not after the 15th.
- R8: A new differing request that arrives while a code is pending replaces the pending code and restarts the tick count from zero.
- R9: With the enable input high, a request equal to the active code leaves nothing pending. Any code that was pending before is dropped, so later crossings and ticks leave the active code unchanged.
- R10: When a request and a rising crossing fall on the same clock edge, the request is taken as pending and that crossing does not apply it. A later crossing does.
- R11: If the enable input is low while a code is pending and no request is strobed, the pending code becomes active after the next clock edge.
- R12: Millisecond ticks received while nothing is pending do not count toward the timeout of a later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe for a new requested code |
| req_code | input | 8 | Requested gain code |
| zc_en | input | 1 | High: wait for a zero crossing or the timeout; low: apply at once |
| sig_neg | input | 1 | Input polarity sample, 1 while the signal is negative |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| active_code | output | 8 | Gain code currently driving the switch array |
| mute | output | 1 | High while the active code is 0 |
| gain_half_db | output | 9 | Signed gain in half-dB steps (0 while muted) |

## Verification
Three events can fall on the same clock edge: a new request, a rising crossing and the last timeout tick. The bench provokes two of these collisions. In the first, it raises the polarity bit for one cycle and then lowers it in the same cycle as a new strobe. The active code must then remain unchanged across that edge, and the new code must be applied only at the next crossing. In the second, a replacing request lands after ten ticks have already counted. Here the bench expects the old code to hold through fifteen further ticks and the replacement to appear only after the sixteenth.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
  localparam int CODE_W = 8;
  localparam int GAIN_W = CODE_W + 1;
  localparam int UNITY_CODE = 192;

  function automatic logic signed [GAIN_W-1:0] code_to_halfdb(input logic [CODE_W-1:0] code);
    logic signed [GAIN_W-1:0] wide;
    wide = $signed({1'b0, code});
    if (code == '0) return '0;
    return wide - GAIN_W'(UNITY_CODE);
  endfunction

  function automatic logic code_is_mute(input logic [CODE_W-1:0] code);
    return (code == '0);
  endfunction
endpackage

// File: rtl/zc_crossing_det.sv
module zc_crossing_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_neg,
  output logic rise_cross
);
  logic neg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= sig_neg;
  end

  // previous sample negative, current non-negative
  assign rise_cross = neg_q & ~sig_neg;
endmodule

// File: rtl/zc_timeout_timer.sv
module zc_timeout_timer #(
  parameter int TIMEOUT_MS = 16,
  localparam int CNT_W = $clog2(TIMEOUT_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run & ~restart & tick & (cnt_q == CNT_W'(TIMEOUT_MS - 1));
  assign count  = cnt_q;
endmodule

// File: rtl/zc_gain_decode.sv
module zc_gain_decode
  import zc_gain_pkg::*;
(
  input  logic [CODE_W-1:0]        code,
  output logic                     mute,
  output logic signed [GAIN_W-1:0] gain_half_db
);
  always_comb begin
    mute         = code_is_mute(code);
    gain_half_db = code_to_halfdb(code);
  end
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
  import zc_gain_pkg::*;
#(
  parameter int TIMEOUT_MS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [CODE_W-1:0]        req_code,
  input  logic                     zc_en,
  input  logic                     sig_neg,
  input  logic                     ms_tick,
  output logic [CODE_W-1:0]        active_code,
  output logic                     mute,
  output logic signed [GAIN_W-1:0] gain_half_db
);
  localparam int CNT_W = $clog2(TIMEOUT_MS + 1);

  logic [CODE_W-1:0] active_q, pend_code_q;
  logic              pend_valid_q;
  logic              crossing, tmo_expire;
  logic [CNT_W-1:0]  tmo_cnt;

  // named events for the checker
  logic apply_now, accept_pend, cancel_pend, flush_pend;

  assign apply_now   = req_valid & ~zc_en;
  assign accept_pend = req_valid & zc_en & (req_code != active_q);
  assign cancel_pend = req_valid & zc_en & (req_code == active_q);
  assign flush_pend  = pend_valid_q & ~req_valid & (crossing | tmo_expire | ~zc_en);

  zc_crossing_det u_cross (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_neg    (sig_neg),
    .rise_cross (crossing)
  );

  zc_timeout_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_pend),
    .run     (pend_valid_q),
    .tick    (ms_tick),
    .expire  (tmo_expire),
    .count   (tmo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= '0;
      pend_code_q  <= '0;
      pend_valid_q <= 1'b0;
    end else begin
      if (apply_now)       active_q <= req_code;
      else if (flush_pend) active_q <= pend_code_q;

      if (accept_pend) pend_code_q <= req_code;

      if (req_valid)       pend_valid_q <= accept_pend;
      else if (flush_pend) pend_valid_q <= 1'b0;
    end
  end

  assign active_code = active_q;

  zc_gain_decode u_dec (
    .code         (active_q),
    .mute         (mute),
    .gain_half_db (gain_half_db)
  );
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk
  import zc_gain_pkg::*;
#(
  parameter int TIMEOUT_MS = 16,
  localparam int CNT_W = $clog2(TIMEOUT_MS + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [CODE_W-1:0]        req_code,
  input logic                     zc_en,
  input logic [CODE_W-1:0]        active_code,
  input logic                     mute,
  input logic signed [GAIN_W-1:0] gain_half_db,
  input logic                     pend_valid_q,
  input logic [CODE_W-1:0]        pend_code_q,
  input logic                     crossing,
  input logic                     tmo_expire,
  input logic [CNT_W-1:0]         tmo_cnt
);
  assert_direct_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !zc_en) |=> (active_code == $past(req_code)));

  assert_muted_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_code == '0) |-> (mute && gain_half_db == '0));

  assert_gain_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_code != '0) |-> (!mute && gain_half_db >= -191 && gain_half_db <= 63));

  assert_hold_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_q && zc_en && !req_valid && !crossing && !tmo_expire) |=> $stable(active_code));

  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_q |-> (tmo_cnt < CNT_W'(TIMEOUT_MS)));

  assert_timeout_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_expire && !req_valid) |=> (active_code == $past(pend_code_q) && !pend_valid_q));

  assert_equal_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && zc_en && req_code == active_code) |=> !pend_valid_q);

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_valid_q && !req_valid) |=> $stable(active_code));
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk #(.TIMEOUT_MS(TIMEOUT_MS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_code     (req_code),
  .zc_en        (zc_en),
  .active_code  (active_code),
  .mute         (mute),
  .gain_half_db (gain_half_db),
  .pend_valid_q (pend_valid_q),
  .pend_code_q  (pend_code_q),
  .crossing     (crossing),
  .tmo_expire   (tmo_expire),
  .tmo_cnt      (tmo_cnt)
);

// File: tb/zc_gain_ctrl_tb_top.sv
module zc_gain_ctrl_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [7:0]        req_code = '0;
  logic              zc_en = 1'b0;
  logic              sig_neg = 1'b0;
  logic              ms_tick = 1'b0;
  logic [7:0]        active_code;
  logic              mute;
  logic signed [8:0] gain_half_db;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] code; string tag; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  zc_gain_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .zc_en(zc_en), .sig_neg(sig_neg), .ms_tick(ms_tick),
    .active_code(active_code), .mute(mute), .gain_half_db(gain_half_db)
  );

  // gain from the dB formula: 31.5 - 0.5*(255-N) dB, counted in half-dB steps
  function automatic int ref_gain(input logic [7:0] n);
    if (n == 0) return 0;
    return 63 - (255 - int'(n));
  endfunction

  // monitor: compare every queued expectation shortly after the edge
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (active_code !== e.code || mute !== (e.code == 0) ||
          int'(gain_half_db) != ref_gain(e.code)) begin
        errors++;
        $display("FAIL %s: code=%0d mute=%0b gain=%0d expected code=%0d mute=%0b gain=%0d",
                 e.tag, active_code, mute, int'(gain_half_db),
                 e.code, (e.code == 0), ref_gain(e.code));
      end
    end
  end

  task automatic step(input logic v, input logic [7:0] c, input logic z, input logic n,
                      input logic t, input logic [7:0] exp_code, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_code = c; zc_en = z; sig_neg = n; ms_tick = t;
    e.code = exp_code; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int cnt, input logic z, input logic n, input logic t,
                      input logic [7:0] exp_code, input string tag);
    for (int i = 0; i < cnt; i++) step(1'b0, 8'd0, z, n, t, exp_code, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1'b0, 1'b0, 1'b0, 8'd0, "R1 reset state");
    // immediate path and decode
    step(1, 8'd200, 0, 0, 0, 8'd200, "R2 direct apply");
    step(1, 8'd255, 0, 0, 0, 8'd255, "R3 max gain");
    step(1, 8'd1,   0, 0, 0, 8'd1,   "R3 min gain");
    step(1, 8'd192, 0, 0, 0, 8'd192, "R3 unity");
    step(1, 8'd0,   0, 0, 0, 8'd0,   "R4 mute code");
    step(1, 8'd128, 0, 0, 0, 8'd128, "R2 direct apply");
    // crossing path
    step(1, 8'd100, 1, 0, 0, 8'd128, "R5 pending held");
    idle(3, 1, 1, 0, 8'd128, "R6 falling edge ignored");
    idle(1, 1, 0, 0, 8'd100, "R5 rising crossing applies");
    step(1, 8'd50, 1, 0, 0, 8'd100, "R5 pending held");
    idle(4, 1, 0, 0, 8'd100, "R6 steady level ignored");
    idle(2, 1, 1, 0, 8'd100, "R6 falling edge ignored");
    idle(1, 1, 0, 0, 8'd50, "R5 rising crossing applies");
    // timeout
    step(1, 8'd77, 1, 0, 0, 8'd50, "R7 pending held");
    idle(15, 1, 0, 1, 8'd50, "R7 before timeout");
    idle(1, 1, 0, 1, 8'd77, "R7 timeout applies");
    idle(1, 1, 0, 0, 8'd77, "R7 after timeout");
    // replacement restarts timer
    step(1, 8'd10, 1, 0, 0, 8'd77, "R8 first request");
    idle(10, 1, 0, 1, 8'd77, "R8 partial count");
    step(1, 8'd20, 1, 0, 0, 8'd77, "R8 replacement");
    idle(15, 1, 0, 1, 8'd77, "R8 restarted count");
    idle(1, 1, 0, 1, 8'd20, "R8 replacement applies");
    // equal request cancels pending
    step(1, 8'd90, 1, 0, 0, 8'd20, "R9 pending set");
    step(1, 8'd20, 1, 0, 0, 8'd20, "R9 equal request");
    idle(1, 1, 1, 0, 8'd20, "R9 no pending");
    idle(1, 1, 0, 0, 8'd20, "R9 crossing no effect");
    idle(20, 1, 0, 1, 8'd20, "R9 ticks no effect");
    // idle ticks do not count
    step(1, 8'd33, 1, 0, 0, 8'd20, "R12 request after idle ticks");
    idle(15, 1, 0, 1, 8'd20, "R12 fresh count");
    idle(1, 1, 0, 1, 8'd33, "R12 timeout applies");
    // request and crossing on one edge
    idle(1, 1, 1, 0, 8'd33, "R10 negative sample");
    step(1, 8'd44, 1, 0, 0, 8'd33, "R10 request beats crossing");
    idle(1, 1, 0, 0, 8'd33, "R10 still pending");
    idle(1, 1, 1, 0, 8'd33, "R10 still pending");
    idle(1, 1, 0, 0, 8'd44, "R10 next crossing applies");
    // enable dropped while pending
    step(1, 8'd60, 1, 0, 0, 8'd44, "R11 pending set");
    idle(1, 0, 0, 0, 8'd60, "R11 enable low applies");
    idle(2, 0, 0, 0, 8'd60, "R11 stable");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule